// File: doc/BRIEF.md
# Extract-Pattern Character Merge Unit

The block works on words of twelve 7-bit characters. A pattern register holds one word. Its characters decide, position by position, which characters of an operand take part in an operation. A pattern character whose lowest code bit is 0 is an extractor, and one whose lowest bit is 1 is a nonextractor. The other bits of a pattern character play no part.

A separate strobe copies the memory word into the pattern register. Three operations then use that pattern, each on a start pulse:

- A masked load fills the accumulator with the selected memory characters and puts a fill character everywhere else.
- A merge overwrites only the selected characters of the accumulator and keeps the rest.
- A dual merge builds a composite of the accumulator and the memory word. It returns that composite both as the new accumulator value and, with a one-cycle write strobe, on the memory write port.

Results are registered and appear one clock after start, together with a one-cycle done pulse. The unit around it supplies the memory word and the current accumulator value, and it takes the new accumulator from the output.

Top module: `xmerge_unit`

## Requirements
- R1: While reset is held, and on the first cycle after it, acc_out is all zeros, mem_wdata is all zeros, mem_we is 0 and done is 0. The pattern register resets to all nonextractors, so a masked load issued before any pattern load yields FILL_CHAR in every position.
- R2: Character i of a word occupies bits [i*CW +: CW], with character 0 in the least significant bits. A pattern character is an extractor exactly when its bit 0 is 0. Its upper bits have no effect on any result.
- R3: When op 2'b00 (masked load) is started, the next acc_out holds the mem_word character at extractor positions and FILL_CHAR at nonextractor positions.
- R4: When op 2'b01 (merge into A) is started, the next acc_out holds the mem_word character at extractor positions and the acc_in character at nonextractor positions.
- R5: When op 2'b10 (dual merge) is started, the next acc_out and the next mem_wdata are the same word. That word holds the acc_in character at extractor positions and the mem_word character at nonextractor positions.
- R6: done is 1 in exactly the cycle after each cycle in which start is 1, for every op value, and is 0 otherwise.
- R7: mem_we is 1 only in the cycle after a start with op 2'b10, and only for one cycle.
- R8: A start with op 2'b11 changes neither acc_out nor mem_wdata and does not raise mem_we, but it still produces done.
- R9: pat_ld with start low copies mem_word into the pattern register for later operations. It raises no done and leaves acc_out unchanged.
- R10: If pat_ld and start are both 1 in the same cycle, the pattern load is dropped. The operation uses the pattern held before that cycle, and that pattern stays in place for the operations that follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the operation selected by op |
| op | input | 2 | 00 masked load, 01 merge into A, 10 dual merge, 11 no operation |
| pat_ld | input | 1 | Load mem_word into the pattern register |
| mem_word | input | NCHAR*CW | Memory operand, or the pattern source when pat_ld is 1 |
| acc_in | input | NCHAR*CW | Current accumulator value |
| acc_out | output | NCHAR*CW | New accumulator value |
| mem_wdata | output | NCHAR*CW | Composite word for memory |
| mem_we | output | 1 | Memory write strobe, one cycle |
| done | output | 1 | Operation finished, one cycle |

## Verification
The bench builds the unit with the default twelve characters of seven bits, but sets FILL_CHAR to 7'h2A rather than zero. Fill positions of a masked load therefore differ from both kept characters and zeroed ones, and a fill swapped for zero or for the accumulator character becomes visible. Its pattern words put random values in the upper code bits. It also includes the all-extractor and all-nonextractor cases, which bring the R2 rule and the full-word edge of each merge direction within reach.

// File: rtl/xmerge_pkg.sv
package xmerge_pkg;
   typedef enum logic [1:0] {
      XM_MLOAD = 2'b00,
      XM_MERGE = 2'b01,
      XM_DUAL  = 2'b10,
      XM_NOP   = 2'b11
   } xm_op_e;
endpackage

// File: rtl/xmerge_lane.sv
module xmerge_lane
   import xmerge_pkg::*;
#(
   parameter int unsigned CW = 7,
   parameter logic [CW-1:0] FILL_CHAR = '0
) (
   input  xm_op_e          op,
   input  logic [CW-1:0]   pat_ch,
   input  logic [CW-1:0]   mem_ch,
   input  logic [CW-1:0]   acc_ch,
   output logic [CW-1:0]   res_ch
);
   logic is_ext;

   // Selection depends only on the low code bit of the pattern character.
   assign is_ext = ~pat_ch[0];

   always_comb begin
      unique case (op)
         XM_MLOAD: res_ch = is_ext ? mem_ch : FILL_CHAR;
         XM_MERGE: res_ch = is_ext ? mem_ch : acc_ch;
         XM_DUAL:  res_ch = is_ext ? acc_ch : mem_ch;
         default:  res_ch = acc_ch;
      endcase
   end
endmodule

// File: rtl/xmerge_patreg.sv
module xmerge_patreg #(
   parameter int unsigned NCHAR = 12,
   parameter int unsigned CW    = 7,
   localparam int unsigned W    = NCHAR * CW
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_req,
   input  logic         block,
   input  logic [W-1:0] din,
   output logic [W-1:0] pat_q
);
   logic [W-1:0] rst_val;

   // The reset pattern marks every position as a nonextractor.
   for (genvar c = 0; c < NCHAR; c++) begin : g_rst
      assign rst_val[c*CW +: CW] = CW'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         pat_q <= rst_val;
      else if (load_req && !block)
         pat_q <= din;
   end
endmodule

// File: rtl/xmerge_unit.sv
module xmerge_unit
   import xmerge_pkg::*;
#(
   parameter int unsigned NCHAR = 12,
   parameter int unsigned CW    = 7,
   parameter logic [CW-1:0] FILL_CHAR = '0,
   localparam int unsigned W    = NCHAR * CW
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [1:0]   op,
   input  logic         pat_ld,
   input  logic [W-1:0] mem_word,
   input  logic [W-1:0] acc_in,
   output logic [W-1:0] acc_out,
   output logic [W-1:0] mem_wdata,
   output logic         mem_we,
   output logic         done
);
   if (NCHAR < 1) begin : g_bad_nchar
      $error("xmerge_unit: NCHAR must be at least 1");
   end
   if (CW < 1) begin : g_bad_cw
      $error("xmerge_unit: CW must be at least 1");
   end

   xm_op_e       op_e;
   logic [W-1:0] pat_q;
   logic [W-1:0] res_w;
   logic         upd_acc;
   logic         upd_mem;

   assign op_e = xm_op_e'(op);

   // A load that coincides with a start is dropped.
   xmerge_patreg #(.NCHAR(NCHAR), .CW(CW)) u_pat (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_req (pat_ld),
      .block    (start),
      .din      (mem_word),
      .pat_q    (pat_q)
   );

   for (genvar c = 0; c < NCHAR; c++) begin : g_lane
      xmerge_lane #(.CW(CW), .FILL_CHAR(FILL_CHAR)) u_lane (
         .op     (op_e),
         .pat_ch (pat_q[c*CW +: CW]),
         .mem_ch (mem_word[c*CW +: CW]),
         .acc_ch (acc_in[c*CW +: CW]),
         .res_ch (res_w[c*CW +: CW])
      );
   end

   assign upd_acc = start && (op_e != XM_NOP);
   assign upd_mem = start && (op_e == XM_DUAL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_out   <= '0;
         mem_wdata <= '0;
         mem_we    <= 1'b0;
         done      <= 1'b0;
      end else begin
         done   <= start;
         mem_we <= upd_mem;
         if (upd_acc) acc_out   <= res_w;
         if (upd_mem) mem_wdata <= res_w;
      end
   end
endmodule

// File: rtl/xmerge_chk.sv
module xmerge_chk #(
   parameter int unsigned NCHAR = 12,
   parameter int unsigned CW    = 7,
   localparam int unsigned W    = NCHAR * CW
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic [1:0]   op,
   input logic         pat_ld,
   input logic [W-1:0] mem_word,
   input logic [W-1:0] acc_out,
   input logic [W-1:0] mem_wdata,
   input logic         mem_we,
   input logic         done,
   input logic [W-1:0] pat_q
);
   a_r6_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done);
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done);
   a_r7_we_on_dual: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op == 2'b10) |=> mem_we);
   a_r7_we_only_dual: assert property (@(posedge clk) disable iff (!rst_n)
      !(start && op == 2'b10) |=> !mem_we);
   a_r5_same_word: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_wdata == acc_out));
   a_r8_nop_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op == 2'b11) |=> $stable(acc_out));
   a_r9_pat_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (pat_ld && !start) |=> (pat_q == $past(mem_word)));
   a_r10_conflict_keeps_pat: assert property (@(posedge clk) disable iff (!rst_n)
      (pat_ld && start) |=> $stable(pat_q));
endmodule

bind xmerge_unit xmerge_chk #(.NCHAR(NCHAR), .CW(CW)) u_chk (.*);

// File: tb/xmerge_unit_tb.sv
module xmerge_unit_tb_top;
   localparam int unsigned NCHAR = 12;
   localparam int unsigned CW    = 7;
   localparam int unsigned W     = NCHAR * CW;
   localparam logic [CW-1:0] FILL = 7'h2A;
   localparam time CLK_PERIOD = 10ns;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [1:0]   op = 2'b00;
   logic         pat_ld = 1'b0;
   logic [W-1:0] mem_word = '0;
   logic [W-1:0] acc_in = '0;
   logic [W-1:0] acc_out, mem_wdata;
   logic         mem_we, done;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   logic [W-1:0] model_acc;
   logic [W-1:0] model_wd;
   logic [W-1:0] model_pat;

   always #(CLK_PERIOD/2) clk = ~clk;

   xmerge_unit #(.NCHAR(NCHAR), .CW(CW), .FILL_CHAR(FILL)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .pat_ld(pat_ld),
      .mem_word(mem_word), .acc_in(acc_in), .acc_out(acc_out),
      .mem_wdata(mem_wdata), .mem_we(mem_we), .done(done)
   );

   // op, pattern seed, memory seed, accumulator seed
   localparam int VEC [0:9][0:3] = '{
      '{0, 'h5A3, 11, 4},
      '{1, 'h5A3, 23, 7},
      '{2, 'h5A3, 31, 9},
      '{0, 'h000, 41, 2},
      '{1, 'hFFF, 52, 6},
      '{2, 'h000, 63, 8},
      '{2, 'hFFF, 71, 1},
      '{3, 'h0F0, 83, 5},
      '{1, 'h0F0, 97, 3},
      '{0, 'hC3C, 101, 12}
   };

   function automatic logic [W-1:0] mkw(input int seed);
      logic [W-1:0] w;
      for (int i = 0; i < NCHAR; i++)
         w[i*CW +: CW] = CW'((seed*13 + i*37 + i*i + 1) & 127);
      return w;
   endfunction

   // Bit 0 from the seed bit, upper bits scrambled (R2).
   function automatic logic [W-1:0] mkpat(input int seed);
      logic [W-1:0] w;
      for (int i = 0; i < NCHAR; i++)
         w[i*CW +: CW] = CW'((((seed + i*5) * 6) & 126) | ((seed >> i) & 1));
      return w;
   endfunction

   function automatic logic [W-1:0] model(input int o, input logic [W-1:0] p,
                                          input logic [W-1:0] m, input logic [W-1:0] a);
      logic [W-1:0] r;
      for (int i = 0; i < NCHAR; i++) begin
         logic ext;
         ext = (p[i*CW] == 1'b0);
         case (o)
            0: r[i*CW +: CW] = ext ? m[i*CW +: CW] : FILL;
            1: r[i*CW +: CW] = ext ? m[i*CW +: CW] : a[i*CW +: CW];
            default: r[i*CW +: CW] = ext ? a[i*CW +: CW] : m[i*CW +: CW];
         endcase
      end
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic load_pat(input logic [W-1:0] p);
      @(negedge clk);
      pat_ld = 1'b1; mem_word = p;
      @(negedge clk);
      pat_ld = 1'b0;
      model_pat = p;
      chk(done == 1'b0, "R9 no done on pattern load", W'(done), '0);
      chk(acc_out == model_acc, "R9 acc kept on pattern load", acc_out, model_acc);
   endtask

   task automatic run_op(input int o, input logic [W-1:0] m, input logic [W-1:0] a,
                         input bit with_ld, input string req);
      @(negedge clk);
      start = 1'b1; op = 2'(o); mem_word = m; acc_in = a; pat_ld = with_ld;
      if (o != 3) model_acc = model(o, model_pat, m, a);
      if (o == 2) model_wd = model_acc;
      @(negedge clk);
      start = 1'b0; pat_ld = 1'b0;
      chk(acc_out == model_acc, req, acc_out, model_acc);
      chk(done == 1'b1, "R6 done after start", W'(done), W'(1));
      chk(mem_we == (o == 2), "R7 write strobe", W'(mem_we), W'(o == 2));
      chk(mem_wdata == model_wd, (o == 2) ? "R5 memory word" : "R8 memory word held",
          mem_wdata, model_wd);
      @(negedge clk);
      chk(done == 1'b0, "R6 done one cycle", W'(done), '0);
      chk(mem_we == 1'b0, "R7 strobe one cycle", W'(mem_we), '0);
   endtask

   initial begin
      model_acc = '0; model_wd = '0;
      model_pat = mkpat('hFFF);
      repeat (3) @(negedge clk);
      chk(acc_out == '0, "R1 acc reset", acc_out, '0);
      chk(mem_wdata == '0, "R1 wdata reset", mem_wdata, '0);
      chk(mem_we == 1'b0 && done == 1'b0, "R1 strobes reset", W'({mem_we, done}), '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(acc_out == '0 && done == 1'b0, "R1 first cycle after reset", acc_out, '0);
      // Reset pattern is all nonextractors: masked load gives all fill (R1).
      run_op(0, mkw(77), mkw(3), 1'b0, "R1 reset pattern masked load");

      // Table walk
      for (int v = 0; v < 10; v++) begin
         string req;
         case (VEC[v][0])
            0: req = "R3 masked load";
            1: req = "R4 merge into A";
            2: req = "R5 dual merge";
            default: req = "R8 no operation";
         endcase
         if (mkpat(VEC[v][1]) != model_pat) load_pat(mkpat(VEC[v][1]));
         run_op(VEC[v][0], mkw(VEC[v][2]), mkw(VEC[v][3]), 1'b0, req);
      end

      // R2: same low bits, different upper bits, identical result.
      begin
         logic [W-1:0] p2;
         p2 = model_pat ^ {NCHAR{{(CW-1){1'b1}}, 1'b0}};
         load_pat(p2);
         run_op(1, mkw(200), mkw(201), 1'b0, "R2 upper pattern bits ignored");
      end

      // R10: conflicting load is dropped; old pattern used now and later.
      load_pat(mkpat('h000));
      run_op(0, mkpat('hFFF), mkw(5), 1'b1, "R10 op uses old pattern");
      run_op(0, mkw(300), mkw(6), 1'b0, "R10 pattern kept after conflict");

      // R9: a plain load changes what later ops see.
      load_pat(mkpat('hFFF));
      run_op(1, mkw(400), mkw(401), 1'b0, "R9 new pattern in effect");

      // R8: no-op after a dual merge keeps both words.
      run_op(2, mkw(500), mkw(501), 1'b0, "R5 dual merge before no-op");
      run_op(3, mkw(502), mkw(503), 1'b0, "R8 no-op keeps acc");

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule